// File: doc/BRIEF.md
# Bridge Configuration Cycle Router

This block sits on the primary side of a two-port bus bridge. It looks at one configuration cycle during its address phase and decides what the bridge does with it. It compares the address word and bus command against the bridge's secondary and subordinate bus numbers. The decision is one of four:

- turn a Type 1 cycle into a Type 0 cycle on the secondary bus;
- pass a Type 1 cycle down unchanged;
- pass a Type 1 write up unchanged;
- leave the cycle alone.

For a converted cycle the block builds the Type 0 address. That address has a one-hot device select in its upper bits. The block also flags a cycle that can reach no device, and it asks for a disconnect once the single allowed data phase has finished.

The decision and the address are registered on the clock edge after a valid address-phase strobe. They stay fixed until the surrounding bridge logic signals completion with `done_i`. The bus handshake, the delayed-transaction queues and the configuration registers are outside this block. The two bus numbers arrive as plain inputs.

Top module: `cfg_route`

## Requirements
- R1: The outcome is ignore (route 00, address output all zeros) unless two things hold: the command is a configuration read (4'b1010) or write (4'b1011), and address bits [1:0] are 01b.
- R2: When the bus number in address bits [23:16] equals the secondary bus number, the outcome is convert (01). The converted address keeps bits [10:2] of the input and forces bits [15:11] and [1:0] to zero.
- R3: In a converted address, a device number N in bits [15:11] with N below 16 sets address bit 16+N. Every other bit in [31:16] is zero.
- R4: A converted cycle whose device number is 16 or above is still converted, but with bits [31:16] all zero. It raises `no_target_o` so that the cycle can be ended by master abort.
- R5: A cycle is forwarded down unchanged (10) when all of these hold: it is a configuration read or write, bits [1:0] are 01b, and its bus number is strictly above the secondary bus number and at most the subordinate bus number. The address output equals the input address.
- R6: A cycle is forwarded up unchanged (11) only when all of these hold:
  - it is a configuration write;
  - bits [1:0] are 01b;
  - device bits [15:11] are 11111b;
  - function bits [10:8] are 111b;
  - the bus number is below the secondary bus number or above the subordinate bus number.

  The address output equals the input address.
- R7: Exactly one outcome is reported per cycle, with the encoding 00 ignore, 01 convert, 10 down, 11 up. `no_target_o` is only ever set with convert.
- R8: A strobe on `addr_valid_i` while nothing is held is registered on the next clock edge and raises `route_valid_o`. While held, the route, the address and the flag stay stable, and further strobes are ignored.
- R9: `done_i` while a result is held clears `route_valid_o`, the route, the address, `no_target_o` and `disconnect_o` on the next edge.
- R10: For a held convert result, `data_ack_i` marks the end of the first data phase. `disconnect_o` rises on the next edge and stays high until `done_i`. For any other outcome it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_valid_i | input | 1 | Address phase strobe |
| addr_i | input | 32 | Address word of the cycle |
| cmd_i | input | 4 | Bus command |
| sec_bus_i | input | 8 | Secondary bus number |
| sub_bus_i | input | 8 | Subordinate bus number |
| data_ack_i | input | 1 | Data phase completed |
| done_i | input | 1 | Release the held result |
| route_valid_o | output | 1 | A result is held |
| route_o | output | 2 | Outcome code |
| addr_o | output | 32 | Translated or forwarded address |
| no_target_o | output | 1 | Converted cycle selects no device |
| disconnect_o | output | 1 | Request disconnect after first data phase |

## Verification
The bench goes after the range edges, because each bound has its own kind of comparison:

- A bus number equal to the secondary number must convert. A design using an inclusive lower bound for the down test would forward it instead.
- A bus number equal to the subordinate number must go down. An exclusive upper bound would drop it.
- Just outside the range, the up path is probed with a write and a read, and with a device or function field one short of all ones. A design that loosened any of these conditions would forward a cycle upstream that it should leave alone.

Device numbers 0, 15 and 16 and above test the select decoding. An off-by-one decoder either sets the wrong bit or misses the abort flag. Extra strobes while a result is held, and data acks on non-converted cycles, catch a design that overwrites its result or disconnects the wrong cycles.

// File: rtl/cfg_route_pkg.sv
`timescale 1ns/1ps
package cfg_route_pkg;
  typedef enum logic [1:0] {
    ROUTE_IGNORE  = 2'b00,
    ROUTE_CONVERT = 2'b01,
    ROUTE_DOWN    = 2'b10,
    ROUTE_UP      = 2'b11
  } route_e;

  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
  localparam logic [1:0] LOW_TYPE1  = 2'b01;
endpackage

// File: rtl/cfg_route_decode.sv
`timescale 1ns/1ps
module cfg_route_decode
  import cfg_route_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BUS_W   = 8,
  parameter int BUS_LSB = 16,
  parameter int DEV_W   = 5,
  parameter int DEV_LSB = 11,
  parameter int FN_W    = 3,
  parameter int FN_LSB  = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        cmd_i,
  input  logic [BUS_W-1:0]  sec_bus_i,
  input  logic [BUS_W-1:0]  sub_bus_i,
  output route_e            route_o
);
  logic [BUS_W-1:0] bus;
  logic [DEV_W-1:0] dev;
  logic [FN_W-1:0]  fn;
  logic is_rd, is_wr, is_t1, in_excl, in_incl, bcast;

  assign bus     = addr_i[BUS_LSB +: BUS_W];
  assign dev     = addr_i[DEV_LSB +: DEV_W];
  assign fn      = addr_i[FN_LSB +: FN_W];
  assign is_rd   = (cmd_i == CMD_CFG_RD);
  assign is_wr   = (cmd_i == CMD_CFG_WR);
  assign is_t1   = (addr_i[1:0] == LOW_TYPE1);
  assign in_excl = (bus > sec_bus_i) && (bus <= sub_bus_i);
  assign in_incl = (bus >= sec_bus_i) && (bus <= sub_bus_i);
  assign bcast   = (&dev) && (&fn);

  always_comb begin
    route_o = ROUTE_IGNORE;
    if ((is_rd || is_wr) && is_t1) begin
      if (bus == sec_bus_i)               route_o = ROUTE_CONVERT;
      else if (in_excl)                   route_o = ROUTE_DOWN;
      else if (is_wr && bcast && !in_incl) route_o = ROUTE_UP;
    end
  end
endmodule

// File: rtl/cfg_route_xlate.sv
`timescale 1ns/1ps
module cfg_route_xlate
  import cfg_route_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int N_SEL    = 16,
  parameter int SEL_LSB  = 16,
  parameter int DEV_W    = 5,
  parameter int DEV_LSB  = 11,
  parameter int KEEP_LSB = 2,
  parameter int KEEP_MSB = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  route_e            route_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              no_target_o
);
  localparam int KEEP_W = KEEP_MSB - KEEP_LSB + 1;

  logic [DEV_W-1:0]  dev;
  logic [N_SEL-1:0]  sel;
  logic [ADDR_W-1:0] conv;

  assign dev = addr_i[DEV_LSB +: DEV_W];

  for (genvar g = 0; g < N_SEL; g++) begin : g_sel
    assign sel[g] = (dev == DEV_W'(g));
  end

  always_comb begin
    conv = '0;
    conv[KEEP_LSB +: KEEP_W] = addr_i[KEEP_LSB +: KEEP_W];
    conv[SEL_LSB +: N_SEL]   = sel;
  end

  always_comb begin
    unique case (route_i)
      ROUTE_CONVERT:       addr_o = conv;
      ROUTE_DOWN, ROUTE_UP: addr_o = addr_i;
      default:             addr_o = '0;
    endcase
  end

  assign no_target_o = (route_i == ROUTE_CONVERT) && !(|sel);
endmodule

// File: rtl/cfg_route_phase.sv
`timescale 1ns/1ps
module cfg_route_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic ack_i,
  input  logic clr_i,
  output logic disc_o
);
  logic disc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             disc_q <= 1'b0;
    else if (clr_i)          disc_q <= 1'b0;
    else if (arm_i && ack_i) disc_q <= 1'b1;
  end

  assign disc_o = disc_q;
endmodule

// File: rtl/cfg_route.sv
`timescale 1ns/1ps
module cfg_route
  import cfg_route_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 8,
  parameter int N_SEL  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        cmd_i,
  input  logic [BUS_W-1:0]  sec_bus_i,
  input  logic [BUS_W-1:0]  sub_bus_i,
  input  logic              data_ack_i,
  input  logic              done_i,
  output logic              route_valid_o,
  output logic [1:0]        route_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              no_target_o,
  output logic              disconnect_o
);
  localparam int BUS_LSB = 16;
  localparam int SEL_LSB = ADDR_W - N_SEL;

  route_e            route_d, route_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              nt_d, nt_q, valid_q;
  logic              capture, release_h;

  assign capture   = addr_valid_i && !valid_q;
  assign release_h = done_i && valid_q;

  cfg_route_decode #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .BUS_LSB(BUS_LSB)) u_decode (
    .addr_i   (addr_i),
    .cmd_i    (cmd_i),
    .sec_bus_i(sec_bus_i),
    .sub_bus_i(sub_bus_i),
    .route_o  (route_d)
  );

  cfg_route_xlate #(.ADDR_W(ADDR_W), .N_SEL(N_SEL), .SEL_LSB(SEL_LSB)) u_xlate (
    .addr_i     (addr_i),
    .route_i    (route_d),
    .addr_o     (addr_d),
    .no_target_o(nt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      route_q <= ROUTE_IGNORE;
      addr_q  <= '0;
      nt_q    <= 1'b0;
    end else if (capture) begin
      valid_q <= 1'b1;
      route_q <= route_d;
      addr_q  <= addr_d;
      nt_q    <= nt_d;
    end else if (release_h) begin
      valid_q <= 1'b0;
      route_q <= ROUTE_IGNORE;
      addr_q  <= '0;
      nt_q    <= 1'b0;
    end
  end

  cfg_route_phase u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (valid_q && (route_q == ROUTE_CONVERT)),
    .ack_i (data_ack_i),
    .clr_i (release_h),
    .disc_o(disconnect_o)
  );

  assign route_valid_o = valid_q;
  assign route_o       = route_q;
  assign addr_o        = addr_q;
  assign no_target_o   = nt_q;
endmodule

// File: rtl/cfg_route_chk.sv
`timescale 1ns/1ps
module cfg_route_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_valid_i,
  input logic              data_ack_i,
  input logic              done_i,
  input logic              route_valid_o,
  input logic [1:0]        route_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              no_target_o,
  input logic              disconnect_o
);
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_valid_o && !done_i |=> $stable(route_o) && $stable(addr_o) && $stable(no_target_o)); // R8
  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_i && !route_valid_o |=> route_valid_o); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_valid_o && done_i |=> !route_valid_o && !disconnect_o); // R9
  AST_ONE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_valid_o && route_o == 2'b01 |-> $onehot0(addr_o[ADDR_W-1:16]) && addr_o[1:0] == 2'b00); // R3
  AST_NT_IS_CONVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_target_o |-> route_o == 2'b01 && addr_o[ADDR_W-1:16] == '0); // R4
  AST_UP_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_valid_o && route_o == 2'b11 |-> addr_o[15:8] == 8'hFF && addr_o[1:0] == 2'b01); // R6
  AST_DISC_CONVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disconnect_o |-> route_valid_o && route_o == 2'b01); // R10
  AST_DISC_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(disconnect_o) |-> $past(data_ack_i)); // R10
  AST_IDLE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_valid_o |-> route_o == 2'b00 && !no_target_o); // R7
endmodule

bind cfg_route cfg_route_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_valid_i (addr_valid_i),
  .data_ack_i   (data_ack_i),
  .done_i       (done_i),
  .route_valid_o(route_valid_o),
  .route_o      (route_o),
  .addr_o       (addr_o),
  .no_target_o  (no_target_o),
  .disconnect_o (disconnect_o)
);

// File: tb/tb_cfg_route.sv
`timescale 1ns/1ps
module tb_cfg_route;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [3:0]  cmd_i = '0;
  logic [7:0]  sec_bus_i = '0;
  logic [7:0]  sub_bus_i = '0;
  logic        data_ack_i = 1'b0;
  logic        done_i = 1'b0;
  logic        route_valid_o;
  logic [1:0]  route_o;
  logic [31:0] addr_o;
  logic        no_target_o;
  logic        disconnect_o;

  int n_chk = 0;
  int n_err = 0;
  bit seen = 1'b0;

  typedef struct {
    logic [1:0]  r;
    logic        nt;
    logic [31:0] a;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk_i = ~clk_i;

  cfg_route dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int bus, input int dev, input int fn, input int rg, input logic [1:0] lo);
    return {8'h00, 8'(bus), 5'(dev), 3'(fn), 6'(rg), lo};
  endfunction

  function automatic exp_t model(input logic [31:0] a, input logic [3:0] cmd,
                                 input logic [7:0] sec, input logic [7:0] sub, input string tag);
    exp_t e;
    logic [7:0] bus;
    logic [4:0] dev;
    bus = a[23:16];
    dev = a[15:11];
    e.r = 2'b00; e.nt = 1'b0; e.a = '0; e.tag = tag;
    if ((cmd == 4'b1010 || cmd == 4'b1011) && a[1:0] == 2'b01) begin
      if (bus == sec) begin
        e.r = 2'b01;
        e.a[10:2] = a[10:2];
        if (dev < 16) e.a[16 + int'(dev)] = 1'b1;
        else e.nt = 1'b1;
      end else if (bus > sec && bus <= sub) begin
        e.r = 2'b10; e.a = a;
      end else if (cmd == 4'b1011 && dev == 5'h1f && a[10:8] == 3'h7 && (bus < sec || bus > sub)) begin
        e.r = 2'b11; e.a = a;
      end
    end
    return e;
  endfunction

  // driver: pushes expectation, drives one cycle, probes hold/disconnect/release
  task automatic run(input logic [31:0] a, input logic [3:0] cmd,
                     input logic [7:0] sec, input logic [7:0] sub, input string tag);
    exp_t e;
    e = model(a, cmd, sec, sub, tag);
    q.push_back(e);
    @(negedge clk_i);
    addr_i = a; cmd_i = cmd; sec_bus_i = sec; sub_bus_i = sub; addr_valid_i = 1'b1;
    @(negedge clk_i);
    addr_valid_i = 1'b0;
    addr_i = ~a; sec_bus_i = sec + 8'd1; addr_valid_i = 1'b1;
    @(negedge clk_i);
    addr_valid_i = 1'b0;
    chk(route_valid_o && addr_o == e.a && route_o == e.r, "R8 held result overwritten",
        {route_o, addr_o}, {e.r, e.a});
    chk(!disconnect_o, "R10 disconnect before data phase", disconnect_o, 0);
    data_ack_i = 1'b1;
    @(negedge clk_i);
    data_ack_i = 1'b0;
    chk(disconnect_o == (e.r == 2'b01), "R10 disconnect after data phase", disconnect_o, e.r == 2'b01);
    @(negedge clk_i);
    chk(disconnect_o == (e.r == 2'b01), "R10 disconnect held", disconnect_o, e.r == 2'b01);
    done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
    chk(!route_valid_o && !disconnect_o && route_o == 2'b00 && addr_o == '0 && !no_target_o,
        "R9 release", {route_valid_o, disconnect_o, route_o, addr_o}, 0);
  endtask

  // monitor: compares the first cycle of each held result against the queue
  initial begin
    forever begin
      @(negedge clk_i);
      if (route_valid_o && !seen) begin
        exp_t e;
        seen = 1'b1;
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected result", route_o, 0);
        end else begin
          e = q.pop_front();
          chk(route_o == e.r, {e.tag, " R7 route"}, route_o, e.r);
          chk(addr_o == e.a, {e.tag, " R3 address"}, addr_o, e.a);
          chk(no_target_o == e.nt, {e.tag, " R4 no_target"}, no_target_o, e.nt);
        end
      end else if (!route_valid_o) begin
        seen = 1'b0;
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!route_valid_o && route_o == 2'b00 && addr_o == '0 && !no_target_o && !disconnect_o,
        "reset state", {route_valid_o, route_o, addr_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2/R3 convert, devices 3, 0, 15
    run(mk(5, 3, 2, 10, 2'b01), 4'b1011, 8'd5, 8'd9, "R2 convert dev3");
    run(mk(5, 0, 7, 63, 2'b01), 4'b1010, 8'd5, 8'd9, "R3 convert dev0");
    run(mk(5, 15, 1, 1, 2'b01), 4'b1010, 8'd5, 8'd9, "R3 convert dev15");
    // R4 no select
    run(mk(5, 16, 0, 4, 2'b01), 4'b1011, 8'd5, 8'd9, "R4 dev16");
    run(mk(5, 31, 7, 4, 2'b01), 4'b1011, 8'd5, 8'd9, "R4 dev31 at secondary");
    // R5 down, bounds
    run(mk(6, 2, 0, 0, 2'b01), 4'b1010, 8'd5, 8'd9, "R5 down low edge");
    run(mk(9, 4, 1, 8, 2'b01), 4'b1011, 8'd5, 8'd9, "R5 down subordinate");
    run(mk(10, 4, 1, 8, 2'b01), 4'b1010, 8'd5, 8'd9, "R5 above subordinate read");
    run(mk(7, 31, 7, 0, 2'b01), 4'b1011, 8'd5, 8'd9, "R5 broadcast in range");
    // R6 up
    run(mk(2, 31, 7, 0, 2'b01), 4'b1011, 8'd5, 8'd9, "R6 up below");
    run(mk(10, 31, 7, 5, 2'b01), 4'b1011, 8'd5, 8'd9, "R6 up above");
    run(mk(10, 31, 7, 5, 2'b01), 4'b1010, 8'd5, 8'd9, "R6 read not up");
    run(mk(2, 30, 7, 0, 2'b01), 4'b1011, 8'd5, 8'd9, "R6 device not all ones");
    run(mk(2, 31, 6, 0, 2'b01), 4'b1011, 8'd5, 8'd9, "R6 function not all ones");
    // R1 ignore
    run(mk(5, 3, 0, 0, 2'b00), 4'b1011, 8'd5, 8'd9, "R1 type0");
    run(mk(5, 3, 0, 0, 2'b11), 4'b1010, 8'd5, 8'd9, "R1 low bits 11");
    run(mk(6, 3, 0, 0, 2'b01), 4'b0110, 8'd5, 8'd9, "R1 memory read");
    // other register values
    run(mk(0, 8, 3, 20, 2'b01), 4'b1010, 8'd0, 8'd255, "R2 convert bus0");
    run(mk(255, 1, 0, 0, 2'b01), 4'b1011, 8'd0, 8'd255, "R5 down bus255");
    repeat (2) @(negedge clk_i);
    chk(q.size() == 0, "R8 missing results", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule